// File: doc/BRIEF.md
# Flash Fault Status Register with Alert Request

This block keeps a twelve-bit record of hardware faults seen by a flash controller and turns that record into a level alert request for a downstream alert sender. Hardware raises a fault by pulsing one bit of a per-bit set vector, and the matching status bit latches. Ten of the bits are permanent: software can read them but cannot clear them, and they hold until reset. The other two bits track an uncorrectable storage ECC error (bit 7) and a storage integrity failure (bit 8). Software clears either of them by writing a zero to its position.

The alert request is registered. It stays high for as long as any status bit is set. When the only causes were bits 7 and 8, software can silence the alert during boot-image selection: it clears those bits, and the request drops once the receiver has acknowledged it. The block also drives a constant five-entry classification vector. The fault-register alert at index 2 is marked recoverable, so the receiver decides how severe it is.

Top module: `fault_alert_reg`

## Requirements
- R1: While reset (active-low, asynchronous) is applied and right after it is released, the read data is all zero and the alert request is low.
- R2: A one on `hw_set_i[b]` for one cycle makes bit b of `rd_data_o` read one after the next rising clock edge.
- R3: Bits 0-6 and 9-11 stay at one after they are set, whatever value software writes to them, until reset.
- R4: A write with data bit 7 (or bit 8) at zero clears that status bit at the next edge. A write with that data bit at one leaves it unchanged.
- R5: If a hardware set and a software zero-write hit the same clearable bit in one cycle, the bit ends up set.
- R6: Read-data bits 12-15 always read zero, even after writes of ones to them.
- R7: `alert_req_o` goes high one edge after any status bit is set. It stays high while any bit is set, even if acknowledges arrive.
- R8: Once no bit is set, `alert_req_o` falls one edge after the later of two events: the last bit clearing, or an acknowledge being seen while the request is high. With no acknowledge it stays high.
- R9: `alert_fatal_o` equals 5'b01010, so entry 2 (this register's alert) is recoverable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_set_i | input | 12 | Per-bit hardware fault set pulses |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 16 | Software write data |
| rd_data_o | output | 16 | Status read data, upper bits zero |
| alert_ack_i | input | 1 | Acknowledge from the alert receiver side |
| alert_req_o | output | 1 | Registered level alert request |
| alert_fatal_o | output | 5 | Per-alert fatal classification vector |

## Verification
The assertions assume that `hw_set_i`, `wr_en_i`, `wr_data_i` and `alert_ack_i` are synchronous to the clock and stable around each rising edge. They also assume an acknowledge only carries meaning while the request is high. The bench keeps to this: it changes every input on the falling edge, it raises the acknowledge only after it has seen the request high, and it holds each pulse for exactly one cycle. Status and request are read back at the falling edge after the edge that updates them.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int unsigned FAULT_W      = 12;
    localparam int unsigned BUS_W        = 16;
    localparam int unsigned ALERT_N      = 5;
    localparam int unsigned FAULT_ALERT  = 2;
    // Bits 7 (storage ECC) and 8 (storage integrity) may be cleared by writing zero
    localparam logic [FAULT_W-1:0] CLEARABLE  = 12'h180;
    localparam logic [ALERT_N-1:0] FATAL_VEC  = 5'b01010;

    typedef struct packed {
        logic [FAULT_W-1:0] status;
    } store_t;

    typedef struct packed {
        logic req;
        logic acked;
    } alert_t;
endpackage

// File: rtl/fsr_bit_store.sv
module fsr_bit_store #(
    parameter int unsigned            W    = fsr_pkg::FAULT_W,
    parameter logic [W-1:0]           CMASK = fsr_pkg::CLEARABLE
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_bits_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] st_d, st_q;

    always_comb begin
        for (int b = 0; b < W; b++) begin
            st_d[b] = st_q[b];
            if (CMASK[b] && wr_en_i && !wr_bits_i[b]) st_d[b] = 1'b0;
            if (set_i[b]) st_d[b] = 1'b1;   // hardware set wins
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q;

    for (genvar g = 0; g < W; g++) begin : g_bit_chk
        assert_hw_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[g] |=> st_q[g]);
        if (CMASK[g]) begin : g_clr
            assert_w0c_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (wr_en_i && !wr_bits_i[g] && !set_i[g]) |=> !st_q[g]);
            assert_set_beats_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (wr_en_i && !wr_bits_i[g] && set_i[g]) |=> st_q[g]);
        end else begin : g_sticky
            assert_sticky_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                st_q[g] |=> st_q[g]);
        end
    end
endmodule

// File: rtl/fsr_alert_ctl.sv
module fsr_alert_ctl #(
    parameter int unsigned W = fsr_pkg::FAULT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] status_i,
    input  logic         ack_i,
    output logic         req_o
);
    import fsr_pkg::*;
    alert_t s_d, s_q;
    logic   any_fault;

    assign any_fault = |status_i;

    always_comb begin
        s_d = s_q;
        if (any_fault) begin
            s_d.req   = 1'b1;
            s_d.acked = s_q.acked | (s_q.req & ack_i);
        end else if (s_q.req && (s_q.acked || ack_i)) begin
            s_d.req   = 1'b0;
            s_d.acked = 1'b0;
        end else begin
            s_d.acked = s_q.acked | (s_q.req & ack_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign req_o = s_q.req;

    assert_req_on_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_fault |=> req_o);
    assert_req_retire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !any_fault && (s_q.acked || ack_i)) |=> !req_o);
    assert_req_hold_unacked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !s_q.acked && !ack_i) |=> req_o);
endmodule

// File: rtl/fault_alert_reg.sv
module fault_alert_reg #(
    parameter int unsigned               FAULT_W   = fsr_pkg::FAULT_W,
    parameter int unsigned               BUS_W     = fsr_pkg::BUS_W,
    parameter int unsigned               ALERT_N   = fsr_pkg::ALERT_N,
    parameter logic [FAULT_W-1:0]        CLEARABLE = fsr_pkg::CLEARABLE,
    parameter logic [ALERT_N-1:0]        FATAL_VEC = fsr_pkg::FATAL_VEC
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [FAULT_W-1:0] hw_set_i,
    input  logic               wr_en_i,
    input  logic [BUS_W-1:0]   wr_data_i,
    output logic [BUS_W-1:0]   rd_data_o,
    input  logic               alert_ack_i,
    output logic               alert_req_o,
    output logic [ALERT_N-1:0] alert_fatal_o
);
    localparam int unsigned PAD_W = BUS_W - FAULT_W;

    logic [FAULT_W-1:0] status;
    logic               unused_hi;

    assign unused_hi = ^wr_data_i[BUS_W-1:FAULT_W];

    fsr_bit_store #(.W(FAULT_W), .CMASK(CLEARABLE)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (hw_set_i),
        .wr_en_i   (wr_en_i),
        .wr_bits_i (wr_data_i[FAULT_W-1:0]),
        .status_o  (status)
    );

    fsr_alert_ctl #(.W(FAULT_W)) u_alert (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .status_i (status),
        .ack_i  (alert_ack_i),
        .req_o  (alert_req_o)
    );

    assign rd_data_o     = {{PAD_W{1'b0}}, status};
    assign alert_fatal_o = FATAL_VEC;

    assert_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[BUS_W-1:FAULT_W] == '0);
    assert_req_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o != '0) |=> alert_req_o);
endmodule

// File: tb/fault_alert_reg_test.sv
`timescale 1ns/1ps
module fault_alert_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] hw_set = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        ack = 1'b0;
    logic        req;
    logic [4:0]  fatal;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    fault_alert_reg uut (
        .clk_i(clk), .rst_ni(rst_n), .hw_set_i(hw_set), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_data_o(rd_data), .alert_ack_i(ack),
        .alert_req_o(req), .alert_fatal_o(fatal)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; hw_set = '0; wr_en = 1'b0; ack = 1'b0;
        cyc(2); rst_n = 1'b1; cyc(1);
    endtask

    task automatic pulse_set(input logic [11:0] m);
        hw_set = m; cyc(1); hw_set = '0;
    endtask

    task automatic write(input logic [15:0] d);
        wr_data = d; wr_en = 1'b1; cyc(1); wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; cyc(1); ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(rd_data == 16'h0, "R1 status after reset", rd_data, 16'h0);
        chk(req == 1'b0, "R1 alert after reset", {15'b0, req}, 16'h0);
    endtask

    task automatic t_set_each();
        for (int b = 0; b < 12; b++) begin
            do_reset();
            pulse_set(12'(1) << b);
            chk(rd_data == (16'(1) << b), "R2 single bit set", rd_data, 16'(1) << b);
        end
    endtask

    task automatic t_sticky();
        do_reset();
        pulse_set(12'hE7F);
        write(16'h0000);
        chk(rd_data == 16'h0E7F, "R3 sticky bits survive zero write", rd_data, 16'h0E7F);
        write(16'hFFFF);
        chk(rd_data == 16'h0E7F, "R3 sticky bits after ones write", rd_data, 16'h0E7F);
    endtask

    task automatic t_w0c();
        do_reset();
        pulse_set(12'h180);
        write(16'hFFFF);
        chk(rd_data == 16'h0180, "R4 write one keeps bits 7/8", rd_data, 16'h0180);
        write(16'hFF7F);
        chk(rd_data == 16'h0100, "R4 zero clears bit 7 only", rd_data, 16'h0100);
        write(16'h0000);
        chk(rd_data == 16'h0000, "R4 zero clears bit 8", rd_data, 16'h0000);
    endtask

    task automatic t_collide();
        do_reset();
        hw_set = 12'h080; wr_data = 16'h0000; wr_en = 1'b1; cyc(1);
        hw_set = '0; wr_en = 1'b0;
        chk(rd_data == 16'h0080, "R5 set beats clear", rd_data, 16'h0080);
    endtask

    task automatic t_upper();
        do_reset();
        write(16'hF000);
        chk(rd_data == 16'h0000, "R6 upper bits read zero", rd_data, 16'h0000);
        pulse_set(12'h001);
        write(16'hFFFF);
        chk(rd_data[15:12] == 4'h0, "R6 upper bits after write", rd_data, 16'h0001);
    endtask

    task automatic t_alert_persist();
        do_reset();
        pulse_set(12'h008);
        chk(req == 1'b0, "R7 request not yet high", {15'b0, req}, 16'h0);
        cyc(1);
        chk(req == 1'b1, "R7 request high after set", {15'b0, req}, 16'h1);
        pulse_ack();
        write(16'h0000);
        cyc(5);
        chk(req == 1'b1, "R7 sticky fault keeps request", {15'b0, req}, 16'h1);
    endtask

    task automatic t_alert_retire();
        do_reset();
        pulse_set(12'h100);
        cyc(1);
        chk(req == 1'b1, "R7 request from bit 8", {15'b0, req}, 16'h1);
        write(16'h0000);
        chk(rd_data == 16'h0, "R4 bit 8 cleared", rd_data, 16'h0);
        cyc(3);
        chk(req == 1'b1, "R8 holds without ack", {15'b0, req}, 16'h1);
        pulse_ack();
        chk(req == 1'b0, "R8 drops after ack", {15'b0, req}, 16'h0);
        // acknowledge first, then clear
        pulse_set(12'h080);
        cyc(1);
        pulse_ack();
        cyc(2);
        chk(req == 1'b1, "R7 ack does not drop while set", {15'b0, req}, 16'h1);
        write(16'h0000);
        chk(req == 1'b1, "R8 still high on clear edge", {15'b0, req}, 16'h1);
        cyc(1);
        chk(req == 1'b0, "R8 drops one cycle after clear", {15'b0, req}, 16'h0);
    endtask

    task automatic t_fatal_vec();
        chk(fatal == 5'b01010, "R9 classification vector", {11'b0, fatal}, 16'h000A);
        chk(fatal[2] == 1'b0, "R9 fault alert recoverable", {15'b0, fatal[2]}, 16'h0);
    endtask

    initial begin
        t_reset();
        t_set_each();
        t_sticky();
        t_w0c();
        t_collide();
        t_upper();
        t_alert_persist();
        t_alert_retire();
        t_fatal_vec();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule